// File: doc/BRIEF.md
# Saturating Float-to-Fixed Converter

This block turns one IEEE single-precision value into a 32-bit integer after multiplying it by 2 raised to a small unsigned scale (0 to 31). A mode input selects a signed (two's complement) or an unsigned result. The fraction is always discarded, so results are truncated toward zero. Values outside the representable range clamp to the nearest limit, and a sticky status flag remembers that a clamp happened until it is cleared.

One conversion is accepted per cycle on a valid strobe. The integer appears on the registered output one cycle later, together with an output valid strobe. NaN operands convert to zero without touching the flag. Infinities are not special-cased: their exponent is large enough to send them down the clamping paths.

Top module: `f2x_sat_conv`

## Requirements
- R1: An operand whose exponent field (bits 30:23) is all ones and whose fraction field (bits 22:0) is nonzero converts to 0x00000000 and leaves the flag unchanged, in either mode.
- R2: With E = exponent field - 127 + scale, a non-NaN operand with E < 0 converts to 0x00000000 and leaves the flag unchanged, in both modes and for either sign bit (bit 31).
- R3: In signed mode (in_signed = 1), a non-NaN operand with E >= 31 converts to 0x80000000 when bit 31 is set and to 0x7FFFFFFF otherwise, and sets the flag except in the case of R4.
- R4: In signed mode with E >= 31, when the 32-bit sum of the operand and (scale << 23) equals 0xCF000000 (a value of exactly -2^31 after scaling), the result is 0x80000000 and the flag is not set.
- R5: In signed mode with 0 <= E <= 30, the result is the magnitude of the scaled value truncated toward zero, negated in two's complement when bit 31 is set; no flag.
- R6: In unsigned mode (in_signed = 0), a non-NaN operand with bit 31 set and E >= 0 converts to 0x00000000 and sets the flag.
- R7: In unsigned mode, a non-NaN positive operand with E >= 32 converts to 0xFFFFFFFF and sets the flag.
- R8: In unsigned mode with 0 <= E <= 31 and bit 31 clear, the result is the scaled value truncated toward zero; no flag.
- R9: An infinity (exponent all ones, fraction zero) follows the clamp paths: signed gives 0x7FFFFFFF or 0x80000000, unsigned gives 0xFFFFFFFF or 0x00000000, and the flag is set.
- R10: out_valid is in_valid delayed by one cycle; out_result takes the converted value one cycle after an accepted operand and holds when in_valid is low.
- R11: The flag, once set, stays set until sat_clear; sat_clear in the same cycle as a clamping conversion leaves the flag clear one cycle later.
- R12: After reset out_valid, out_result and sat_sticky are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 32 | Single-precision operand |
| in_scale | input | 5 | Power-of-two scale added to the exponent |
| in_signed | input | 1 | 1 selects a signed result, 0 unsigned |
| sat_clear | input | 1 | Synchronous clear of the sticky flag, wins over a set |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 32 | Converted integer |
| sat_sticky | output | 1 | Sticky clamp flag |

## Verification
The hardest case to reach is the exemption for an exact -2^31 at a nonzero scale: it appears only when a negative power of two and the scale together land the exponent at exactly 31, which is reached by pairing -1.0 with scale 31 in the table and by sweeping every scale with negative powers of two in both modes against an independent model that tests the value, not the bit sum. The second is a clear colliding with a clamping conversion in the same cycle, which is driven directly after the flag has been shown to survive a non-clamping conversion and idle cycles.

// File: rtl/f2x_pkg.sv
`timescale 1ns/1ps
package f2x_pkg;

  localparam int FP_W     = 32;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int SCALE_W  = 5;
  localparam int INT_W    = 32;
  localparam int EXP_BIAS = 127;
  localparam int EFF_W    = EXP_W + 2;
  localparam int SH_W     = $clog2(INT_W);

  // scaled pattern of an exact most-negative integer
  localparam logic [FP_W-1:0] MIN_INT_PATTERN =
    {1'b1, EXP_W'(EXP_BIAS + INT_W - 1), {FRAC_W{1'b0}}};

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  bexp;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;

  typedef enum logic [2:0] {
    PATH_NAN,
    PATH_TINY,
    PATH_NEG_UNS,
    PATH_CLAMP,
    PATH_SHIFT
  } conv_path_e;

  typedef logic signed [EFF_W-1:0] eff_exp_t;

  // unbiased exponent plus scale
  function automatic eff_exp_t eff_exponent(input logic [EXP_W-1:0] bexp,
                                            input logic [SCALE_W-1:0] scale);
    return eff_exp_t'({{(EFF_W-EXP_W){1'b0}}, bexp})
         + eff_exp_t'({{(EFF_W-SCALE_W){1'b0}}, scale})
         - eff_exp_t'(EXP_BIAS);
  endfunction

  // true when operand + (scale << FRAC_W) lands on the most-negative pattern
  function automatic logic is_min_exempt(input logic [FP_W-1:0] op,
                                         input logic [SCALE_W-1:0] scale);
    logic [FP_W-1:0] lifted;
    lifted = {{(FP_W-SCALE_W-FRAC_W){1'b0}}, scale, {FRAC_W{1'b0}}};
    return (op + lifted) == MIN_INT_PATTERN;
  endfunction

  // in-range signed conversion, truncating toward zero
  function automatic logic [INT_W-1:0] trunc_signed(input logic [FRAC_W-1:0] frac,
                                                    input eff_exp_t e,
                                                    input logic neg);
    logic [INT_W-1:0] aligned;
    logic [INT_W-1:0] mag;
    logic [SH_W-1:0]  sh;
    aligned = {1'b0, 1'b1, frac, {(INT_W-2-FRAC_W){1'b0}}};
    sh      = SH_W'(eff_exp_t'(INT_W - 2) - e);
    mag     = aligned >> sh;
    return neg ? (~mag + 1'b1) : mag;
  endfunction

  // in-range unsigned conversion, truncating toward zero
  function automatic logic [INT_W-1:0] trunc_unsigned(input logic [FRAC_W-1:0] frac,
                                                      input eff_exp_t e);
    logic [INT_W-1:0] aligned;
    logic [SH_W-1:0]  sh;
    aligned = {1'b1, frac, {(INT_W-1-FRAC_W){1'b0}}};
    sh      = SH_W'(eff_exp_t'(INT_W - 1) - e);
    return aligned >> sh;
  endfunction

  // limit chosen by a clamp
  function automatic logic [INT_W-1:0] clamp_value(input logic signed_mode,
                                                   input logic neg);
    if (!signed_mode) return {INT_W{1'b1}};
    return neg ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
  endfunction

endpackage

// File: rtl/f2x_classify.sv
`timescale 1ns/1ps
module f2x_classify
  import f2x_pkg::*;
(
  input  fp_word_t             op_i,
  input  logic [SCALE_W-1:0]   scale_i,
  input  logic                 signed_i,
  output conv_path_e           path_o,
  output eff_exp_t             eff_o,
  output logic                 exempt_o,
  output logic                 sat_event_o
);

  logic is_nan;
  logic is_tiny;
  logic over_signed;
  logic over_unsigned;

  assign eff_o         = eff_exponent(op_i.bexp, scale_i);
  assign is_nan        = (op_i.bexp == {EXP_W{1'b1}}) && (op_i.frac != '0);
  assign is_tiny       = eff_o < eff_exp_t'(0);
  assign over_signed   = eff_o >= eff_exp_t'(INT_W - 1);
  assign over_unsigned = eff_o >= eff_exp_t'(INT_W);
  assign exempt_o      = is_min_exempt(op_i, scale_i);

  // priority: NaN, small magnitude, then mode-specific range tests
  always_comb begin
    if (is_nan)             path_o = PATH_NAN;
    else if (is_tiny)       path_o = PATH_TINY;
    else if (signed_i)      path_o = over_signed ? PATH_CLAMP : PATH_SHIFT;
    else if (op_i.sign)     path_o = PATH_NEG_UNS;
    else if (over_unsigned) path_o = PATH_CLAMP;
    else                    path_o = PATH_SHIFT;
  end

  assign sat_event_o = ((path_o == PATH_CLAMP) && !(signed_i && exempt_o))
                     || (path_o == PATH_NEG_UNS);

endmodule

// File: rtl/f2x_align.sv
`timescale 1ns/1ps
module f2x_align
  import f2x_pkg::*;
(
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              sign_i,
  input  eff_exp_t          eff_i,
  input  logic              signed_i,
  input  conv_path_e        path_i,
  output logic [INT_W-1:0]  value_o
);

  always_comb begin
    unique case (path_i)
      PATH_CLAMP: value_o = clamp_value(signed_i, sign_i);
      PATH_SHIFT: value_o = signed_i ? trunc_signed(frac_i, eff_i, sign_i)
                                     : trunc_unsigned(frac_i, eff_i);
      default:    value_o = '0;
    endcase
  end

endmodule

// File: rtl/f2x_sticky.sv
`timescale 1ns/1ps
module f2x_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

endmodule

// File: rtl/f2x_sat_conv.sv
`timescale 1ns/1ps
module f2x_sat_conv
  import f2x_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [FP_W-1:0]    in_operand,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic               in_signed,
  input  logic               sat_clear,
  output logic               out_valid,
  output logic [INT_W-1:0]   out_result,
  output logic               sat_sticky
);

  fp_word_t          op_w;
  conv_path_e        path_w;
  eff_exp_t          eff_w;
  logic              exempt_w;
  logic              sat_event_w;
  logic              sat_set_w;
  logic [INT_W-1:0]  value_w;

  assign op_w      = in_operand;
  assign sat_set_w = in_valid && sat_event_w;

  f2x_classify u_classify (
    .op_i        (op_w),
    .scale_i     (in_scale),
    .signed_i    (in_signed),
    .path_o      (path_w),
    .eff_o       (eff_w),
    .exempt_o    (exempt_w),
    .sat_event_o (sat_event_w)
  );

  f2x_align u_align (
    .frac_i   (op_w.frac),
    .sign_i   (op_w.sign),
    .eff_i    (eff_w),
    .signed_i (in_signed),
    .path_i   (path_w),
    .value_o  (value_w)
  );

  f2x_sticky u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (sat_set_w),
    .clr_i  (sat_clear),
    .flag_o (sat_sticky)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= value_w;
    end
  end

endmodule

// File: rtl/f2x_sat_conv_chk.sv
`timescale 1ns/1ps
module f2x_sat_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_operand,
  input logic [4:0]  in_scale,
  input logic        in_signed,
  input logic        sat_clear,
  input logic        out_valid,
  input logic [31:0] out_result,
  input logic        sat_sticky,
  input logic        sat_event,
  input logic        exempt
);

  logic       nan_in;
  logic [8:0] biased_sum;
  logic       tiny_in;

  assign nan_in     = (in_operand[30:23] == 8'hFF) && (in_operand[22:0] != 23'd0);
  assign biased_sum = {1'b0, in_operand[30:23]} + {4'b0000, in_scale};
  assign tiny_in    = biased_sum < 9'd127;

  AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nan_in |=> out_result == 32'h0 && !$rose(sat_sticky)); // R1
  AST_TINY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !nan_in && tiny_in |=> out_result == 32'h0 && !$rose(sat_sticky)); // R2
  AST_SIGNED_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_signed && !nan_in && biased_sum >= 9'd158
    |=> out_result == ($past(in_operand[31]) ? 32'h80000000 : 32'h7FFFFFFF)); // R3
  AST_MIN_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_signed && exempt && !sat_clear && !sat_sticky |=> !sat_sticky); // R4
  AST_UNS_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_signed && in_operand[31] |=> out_result == 32'h0); // R6
  AST_UNS_HUGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_signed && !in_operand[31] && !nan_in && biased_sum >= 9'd159 && !sat_clear
    |=> out_result == 32'hFFFFFFFF && sat_sticky); // R7
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_result)); // R10
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky && !sat_clear |=> sat_sticky); // R11
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clear |=> !sat_sticky); // R11
  AST_STICKY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_sticky) |-> $past(in_valid) && $past(sat_event)); // R11

endmodule

bind f2x_sat_conv f2x_sat_conv_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_operand (in_operand),
  .in_scale   (in_scale),
  .in_signed  (in_signed),
  .sat_clear  (sat_clear),
  .out_valid  (out_valid),
  .out_result (out_result),
  .sat_sticky (sat_sticky),
  .sat_event  (sat_event_w),
  .exempt     (exempt_w)
);

// File: tb/f2x_sat_conv_bench.sv
`timescale 1ns/1ps
module f2x_sat_conv_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = 32'h0;
  logic [4:0]  in_scale = 5'd0;
  logic        in_signed = 1'b0;
  logic        sat_clear = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        sat_sticky;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  f2x_sat_conv u_f2x_sat_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_scale(in_scale), .in_signed(in_signed), .sat_clear(sat_clear),
    .out_valid(out_valid), .out_result(out_result), .sat_sticky(sat_sticky)
  );

  // tag[94:71] operand[70:39] scale[38:34] signed[33] result[32:1] flag[0]
  localparam int NV = 29;
  localparam logic [94:0] VECS [NV] = '{
    {"R5 ", 32'h3F800000, 5'd0,  1'b1, 32'h00000001, 1'b0},
    {"R8 ", 32'h3F800000, 5'd0,  1'b0, 32'h00000001, 1'b0},
    {"R5 ", 32'h40490FDB, 5'd0,  1'b1, 32'h00000003, 1'b0},
    {"R5 ", 32'hC0490FDB, 5'd0,  1'b1, 32'hFFFFFFFD, 1'b0},
    {"R8 ", 32'h3F800000, 5'd31, 1'b0, 32'h80000000, 1'b0},
    {"R3 ", 32'h3F800000, 5'd31, 1'b1, 32'h7FFFFFFF, 1'b1},
    {"R4 ", 32'hBF800000, 5'd31, 1'b1, 32'h80000000, 1'b0},
    {"R4 ", 32'hCF000000, 5'd0,  1'b1, 32'h80000000, 1'b0},
    {"R3 ", 32'hCF000001, 5'd0,  1'b1, 32'h80000000, 1'b1},
    {"R3 ", 32'h4F000000, 5'd0,  1'b1, 32'h7FFFFFFF, 1'b1},
    {"R5 ", 32'h4EFFFFFF, 5'd0,  1'b1, 32'h7FFFFF80, 1'b0},
    {"R7 ", 32'h4F800000, 5'd0,  1'b0, 32'hFFFFFFFF, 1'b1},
    {"R8 ", 32'h4F7FFFFF, 5'd0,  1'b0, 32'hFFFFFF00, 1'b0},
    {"R6 ", 32'hBF800000, 5'd0,  1'b0, 32'h00000000, 1'b1},
    {"R2 ", 32'hBF000000, 5'd0,  1'b0, 32'h00000000, 1'b0},
    {"R1 ", 32'h7FC00000, 5'd5,  1'b1, 32'h00000000, 1'b0},
    {"R1 ", 32'hFF800001, 5'd0,  1'b0, 32'h00000000, 1'b0},
    {"R9 ", 32'h7F800000, 5'd0,  1'b1, 32'h7FFFFFFF, 1'b1},
    {"R9 ", 32'hFF800000, 5'd0,  1'b1, 32'h80000000, 1'b1},
    {"R9 ", 32'h7F800000, 5'd0,  1'b0, 32'hFFFFFFFF, 1'b1},
    {"R9 ", 32'hFF800000, 5'd3,  1'b0, 32'h00000000, 1'b1},
    {"R2 ", 32'h00000001, 5'd31, 1'b1, 32'h00000000, 1'b0},
    {"R5 ", 32'h3F000000, 5'd1,  1'b1, 32'h00000001, 1'b0},
    {"R5 ", 32'h3FC00000, 5'd4,  1'b1, 32'h00000018, 1'b0},
    {"R5 ", 32'hBFC00000, 5'd0,  1'b1, 32'hFFFFFFFF, 1'b0},
    {"R2 ", 32'h80000000, 5'd0,  1'b0, 32'h00000000, 1'b0},
    {"R2 ", 32'h3F7FFFFF, 5'd0,  1'b1, 32'h00000000, 1'b0},
    {"R8 ", 32'h447A0000, 5'd10, 1'b0, 32'h000FA000, 1'b0},
    {"R5 ", 32'hC47A0000, 5'd2,  1'b1, 32'hFFFFF060, 1'b0}
  };

  localparam int NS = 6;
  localparam logic [31:0] SWEEP_OPS [NS] = '{
    32'h3F800000, 32'hBF800000, 32'h3FC00000, 32'hC0300000, 32'h4B000001, 32'h3E800000
  };

  // independent model: returns {flag_set, result}
  function automatic logic [32:0] ref_conv(input logic [31:0] x, input int sc, input bit sg);
    int      e;
    longint  m;
    bit      neg;
    neg = x[31];
    e   = int'(x[30:23]) - 127 + sc;
    if (x[30:23] == 8'hFF && x[22:0] != 23'd0) return 33'h0;
    if (e < 0) return 33'h0;
    if (sg) begin
      if (e >= 31) begin
        if (neg && x[22:0] == 23'd0 && e == 31) return {1'b0, 32'h80000000};
        return {1'b1, neg ? 32'h80000000 : 32'h7FFFFFFF};
      end
    end else begin
      if (neg) return {1'b1, 32'h0};
      if (e >= 32) return {1'b1, 32'hFFFFFFFF};
    end
    m = longint'({1'b1, x[22:0]});
    m = (e >= 23) ? (m <<< (e - 23)) : (m >>> (23 - e));
    if (sg && neg) m = -m;
    return {1'b0, 32'(m)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // optional clear cycle, one valid cycle, then sample after the capturing edge
  task automatic drive(input logic [31:0] op, input logic [4:0] sc, input logic sg,
                       input logic clr_first);
    if (clr_first) begin
      @(negedge clk);
      sat_clear = 1'b1;
      in_valid  = 1'b0;
    end
    @(negedge clk);
    sat_clear  = 1'b0;
    in_valid   = 1'b1;
    in_operand = op;
    in_scale   = sc;
    in_signed  = sg;
    @(negedge clk);
    in_valid   = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [94:0] v;
    logic [32:0] ref_v;
    logic [31:0] held;

    repeat (3) @(negedge clk);
    check("R12 reset out_valid", {31'b0, out_valid}, 32'h0);
    check("R12 reset out_result", out_result, 32'h0);
    check("R12 reset sat_sticky", {31'b0, sat_sticky}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 idle after reset", {30'b0, out_valid, sat_sticky}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      drive(v[70:39], v[38:34], v[33], 1'b1);
      check($sformatf("%s table %0d result", v[94:71], i), out_result, v[32:1]);
      check($sformatf("%s table %0d flag", v[94:71], i), {31'b0, sat_sticky}, {31'b0, v[0]});
      check($sformatf("R10 table %0d out_valid", i), {31'b0, out_valid}, 32'h1);
    end

    for (int sc = 0; sc < 32; sc++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int k = 0; k < NS; k++) begin
          ref_v = ref_conv(SWEEP_OPS[k], sc, sg[0]);
          drive(SWEEP_OPS[k], 5'(sc), sg[0], 1'b1);
          check($sformatf("%s sweep op=%h sc=%0d result", sg[0] ? "R5" : "R8",
                          SWEEP_OPS[k], sc), out_result, ref_v[31:0]);
          check($sformatf("R4 sweep op=%h sc=%0d mode=%0d flag", SWEEP_OPS[k], sc, sg),
                {31'b0, sat_sticky}, {31'b0, ref_v[32]});
        end
      end
    end

    // sticky holds across a clean conversion and idle cycles
    drive(32'h4F000000, 5'd0, 1'b1, 1'b1);
    check("R11 flag set by clamp", {31'b0, sat_sticky}, 32'h1);
    drive(32'h3F800000, 5'd0, 1'b1, 1'b0);
    check("R11 clean result", out_result, 32'h1);
    check("R11 flag held after clean op", {31'b0, sat_sticky}, 32'h1);
    held = out_result;
    @(negedge clk);
    check("R10 out_valid drops", {31'b0, out_valid}, 32'h0);
    check("R10 result held while idle", out_result, held);
    repeat (4) @(negedge clk);
    check("R11 flag held while idle", {31'b0, sat_sticky}, 32'h1);

    // clear collides with a clamping conversion
    sat_clear  = 1'b1;
    in_valid   = 1'b1;
    in_operand = 32'h4F800000;
    in_scale   = 5'd0;
    in_signed  = 1'b0;
    @(negedge clk);
    sat_clear = 1'b0;
    in_valid  = 1'b0;
    check("R11 clear wins flag", {31'b0, sat_sticky}, 32'h0);
    check("R7 result in clear cycle", out_result, 32'hFFFFFFFF);
    check("R10 out_valid in clear cycle", {31'b0, out_valid}, 32'h1);

    // a NaN after a set flag leaves it set
    drive(32'hBF800000, 5'd0, 1'b0, 1'b0);
    drive(32'h7FFFFFFF, 5'd9, 1'b0, 1'b0);
    check("R1 NaN result", out_result, 32'h0);
    check("R1 NaN keeps flag", {31'b0, sat_sticky}, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule